// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

A small synchronous static memory that accepts a new read or write on every clock without an idle cycle when the bus turns around. Address and control are registered on a rising edge. The data for that operation follows in the next cycle. Read data is not registered: it goes from the array through to the data bus during the data cycle. Write data is captured on the edge that closes its data cycle, and it is committed to the selected byte lanes on that edge.

Each operation is either a single access or the start of a four-beat burst. With load/advance high, the next address comes from an internal 2-bit beat counter rather than from the address pins. The counter steps either in linear order (wrap-around add) or in interleaved order (XOR) inside an aligned group of four words. A clock enable stalls the whole block. Three chip enables gate the start of new operations. An asynchronous output enable can release the bus at any moment.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, no operation is pending and `dq_oe_o` is low.
- R2: A read is started on a rising edge where `cke_ni`=0, `adv_ld_i`=0, the device is selected and `rw_i`=1. During the next cycle, `dq_o` shows the stored word at that address and `dq_oe_o` is high while `oe_ni` is low.
- R3: A write is started in the same way with `rw_i`=0. The active-low lane selects `bw_ni` (bit k covers `dq` bits 9k+8..9k) are sampled with the address. `dq_i` is sampled on the edge that ends the data cycle, and only the lanes whose select is 0 are updated. `dq_oe_o` is low during the write's data cycle.
- R4: A read issued directly after a write to the same address returns the newly written word, with no dead cycle between them. Reads and writes may alternate on every edge.
- R5: `oe_ni` acts without a clock: raising it forces `dq_oe_o` low at once, and lowering it during a read data cycle restores the drive at once.
- R6: The device is selected only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. A load edge with any of these three deasserted starts no operation. The bus is released in the following cycle, the memory is left unchanged, and a transfer already in its data cycle still completes.
- R7: While `cke_ni`=1, every input except `oe_ni` is ignored and all internal state holds. A read in its data cycle keeps driving the same word, and a write in its data cycle is committed only on the first edge with `cke_ni`=0, using `dq_i` from that edge.
- R8: An edge with `adv_ld_i`=1 that follows an operation continues the same operation type at the next beat and ignores `rw_i`, `addr_i` and the chip enables. With `order_i`=0, beat k uses low address bits (start+k) mod 4, and the upper address bits do not change. The beat count wraps after four beats.
- R9: With `order_i`=1, beat k uses low address bits start XOR k.
- R10: An edge with `adv_ld_i`=1 while no operation is pending starts nothing, and the bus stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high stalls all state |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adv_ld_i | input | 1 | 0 loads a new address, 1 advances the burst |
| rw_i | input | 1 | 1 read, 0 write (sampled on load) |
| addr_i | input | ADDR_W (6) | Word address |
| bw_ni | input | LANES (4) | Per-lane write selects, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W (36) | Write data from the bus |
| dq_o | output | LANES*LANE_W (36) | Flow-through read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
A corrupted address or beat counter shows up as a wrong word on `dq_o` in the very next data cycle, because nothing buffers the read path. An op-type or valid flag that is set wrongly shows up at once as wrong drive timing on `dq_oe_o`. Errors in write lanes or write commit timing stay hidden in the array until that address is read back. The sweep therefore writes every address, reads every address, then runs burst, stall and deselect cases against a reference memory, so that each stored word is checked on a later read.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} burst_ord_e;

  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input burst_ord_e ord);
    return (ord == ORD_INTERLEAVE) ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/zbt_addr_gen.sv
module zbt_addr_gen
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              adv_ld_i,
  input  logic              sel_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              order_i,
  output logic              ph_valid_o,
  output logic              ph_write_o,
  output logic [ADDR_W-1:0] ph_addr_o,
  output logic [LANES-1:0]  ph_be_o
);
  localparam int HI_W = ADDR_W - 2;

  logic              valid_q, write_q;
  logic [ADDR_W-1:0] addr_q, base_q;
  logic [LANES-1:0]  be_q;
  logic [1:0]        cnt_q, cnt_n;
  burst_ord_e        ord;

  assign ord   = burst_ord_e'(order_i);
  assign cnt_n = cnt_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      be_q    <= '0;
      cnt_q   <= '0;
    end else if (!cke_ni) begin
      if (!adv_ld_i) begin
        valid_q <= sel_i;
        write_q <= ~rw_i;
        addr_q  <= addr_i;
        base_q  <= addr_i;
        be_q    <= ~bw_ni;
        cnt_q   <= '0;
      end else if (valid_q) begin
        // burst beat: type kept, low bits from counter
        cnt_q  <= cnt_n;
        addr_q <= {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_n, ord)};
        be_q   <= ~bw_ni;
      end
    end
  end

  assign ph_valid_o = valid_q;
  assign ph_write_o = write_q;
  assign ph_addr_o  = addr_q;
  assign ph_be_o    = be_q;

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(valid_q) && $stable(addr_q) && $stable(write_q)));

  p_deselect_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && !sel_i) |=> !valid_q);

  p_burst_upper_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_ld_i && valid_q) |=>
      (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]) && write_q == $past(write_q)));

  p_idle_advance_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && adv_ld_i && !valid_q) |=> !valid_q);

  initial assert (HI_W >= 1) else $error("ADDR_W must exceed 2");
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[addr_i];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_ni,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    adv_ld_i,
  input  logic                    rw_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    order_i,
  input  logic                    oe_ni,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              sel, ph_valid, ph_write, commit;
  logic [ADDR_W-1:0] ph_addr;
  logic [LANES-1:0]  ph_be;
  logic [DATA_W-1:0] rdata;

  assign sel = ~ce1_ni & ce2_i & ~ce3_ni;

  zbt_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cke_ni    (cke_ni),
    .adv_ld_i  (adv_ld_i),
    .sel_i     (sel),
    .rw_i      (rw_i),
    .addr_i    (addr_i),
    .bw_ni     (bw_ni),
    .order_i   (order_i),
    .ph_valid_o(ph_valid),
    .ph_write_o(ph_write),
    .ph_addr_o (ph_addr),
    .ph_be_o   (ph_be)
  );

  // write lands on the edge closing its data cycle
  assign commit = ~cke_ni & ph_valid & ph_write;

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (commit),
    .be_i   (ph_be),
    .addr_i (ph_addr),
    .wdata_i(dq_i),
    .rdata_o(rdata)
  );

  assign dq_o    = rdata;
  assign dq_oe_o = ph_valid & ~ph_write & ~oe_ni;

  p_write_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && sel && !rw_i) |=> !dq_oe_o);

  p_deselect_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && !sel) |=> !dq_oe_o);
endmodule

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cke_ni = 1'b0, ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic        adv_ld_i = 1'b0, rw_i = 1'b1, order_i = 1'b0, oe_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [3:0]  bw_ni = 4'hf;
  logic [35:0] dq_i = '0, dq_o;
  logic        dq_oe_o;

  int n_cmp = 0, n_bad = 0;

  logic [35:0] ref_mem [64];
  logic        mv = 1'b0, mw = 1'b0;
  logic [5:0]  ma = '0, mbase = '0;
  logic [3:0]  mbwn = 4'hf;
  logic [1:0]  mcnt = '0;

  always #10 clk_i = ~clk_i;

  zbt_sram u0 (.*);

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] pat(input logic [5:0] a, input logic [2:0] s);
    return {a, s, a ^ 6'h2a, ~s, a, 3'b101, ~a, s + 3'd1};
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] d,
                                        input logic [3:0] bwn);
    logic [35:0] r = old;
    for (int k = 0; k < 4; k++) if (!bwn[k]) r[k*9 +: 9] = d[k*9 +: 9];
    return r;
  endfunction

  // one clock: check current data phase, drive inputs, advance reference model
  task automatic cyc(input string tag, input logic cke, input logic [2:0] ce_on,
                     input logic adv, input logic rd, input logic [5:0] a,
                     input logic [3:0] bwn, input logic [35:0] d);
    chk({tag, " drive"}, 36'(dq_oe_o), 36'(mv && !mw));
    if (mv && !mw) chk({tag, " data"}, dq_o, ref_mem[ma]);
    cke_ni = cke; ce1_ni = !ce_on[0]; ce2_i = ce_on[1]; ce3_ni = !ce_on[2];
    adv_ld_i = adv; rw_i = rd; addr_i = a; bw_ni = bwn; dq_i = d;
    if (!cke) begin
      if (mv && mw) ref_mem[ma] = merge(ref_mem[ma], d, mbwn);
      if (!adv) begin
        mv = (ce_on == 3'b111); mw = !rd; ma = a; mbase = a; mcnt = 0; mbwn = bwn;
      end else if (mv) begin
        mcnt = mcnt + 2'd1;
        ma = {mbase[5:2], order_i ? (mbase[1:0] ^ mcnt) : (mbase[1:0] + mcnt)};
        mbwn = bwn;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic nop(input string tag, input logic [35:0] d);
    cyc(tag, 1'b0, 3'b000, 1'b0, 1'b1, 6'd0, 4'hf, d);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 reset", 36'(dq_oe_o), 36'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", 36'(dq_oe_o), 36'd0);

    // R3: write every address back to back, all lanes
    for (int a = 0; a < 64; a++)
      cyc("R3 fill", 1'b0, 3'b111, 1'b0, 1'b0, 6'(a), 4'h0, a == 0 ? '0 : pat(6'(a - 1), 3'd1));
    nop("R3 fill", pat(6'd63, 3'd1));
    // R2: read every address back to back
    for (int a = 0; a < 64; a++) cyc("R2 read", 1'b0, 3'b111, 1'b0, 1'b1, 6'(a), 4'hf, '0);
    nop("R2 read", '0);

    // R3: partial lanes
    cyc("R3 lanes", 1'b0, 3'b111, 1'b0, 1'b0, 6'd5, 4'b1010, '0);
    cyc("R3 lanes", 1'b0, 3'b111, 1'b0, 1'b1, 6'd5, 4'hf, 36'hfff_fff_fff);
    nop("R3 lanes", '0);

    // R4: alternating write/read, same address
    for (int i = 0; i < 8; i++) begin
      cyc("R4 wr", 1'b0, 3'b111, 1'b0, 1'b0, 6'(8 * i + 2), 4'h0, '0);
      cyc("R4 rd", 1'b0, 3'b111, 1'b0, 1'b1, 6'(8 * i + 2), 4'hf, pat(6'(i), 3'd6));
    end
    nop("R4 tail", '0);

    // R5: asynchronous output enable
    cyc("R5 setup", 1'b0, 3'b111, 1'b0, 1'b1, 6'd3, 4'hf, '0);
    oe_ni = 1'b1; #1;
    chk("R5 release", 36'(dq_oe_o), 36'd0);
    oe_ni = 1'b0; #1;
    chk("R5 restore", 36'(dq_oe_o), 36'd1);
    nop("R5 tail", '0);

    // R6: each chip enable deasserted on a write attempt, after a pending read
    for (int k = 0; k < 3; k++) begin
      cyc("R6 rd", 1'b0, 3'b111, 1'b0, 1'b1, 6'(40 + k), 4'hf, '0);
      cyc("R6 desel", 1'b0, 3'b111 & ~(3'b001 << k), 1'b0, 1'b0, 6'(40 + k), 4'h0, '0);
      cyc("R6 idle", 1'b0, 3'b111, 1'b0, 1'b1, 6'(40 + k), 4'hf, 36'h5a5a5a5a5);
      nop("R6 check", '0);
    end
    // R10: advance with nothing pending
    cyc("R10 desel", 1'b0, 3'b000, 1'b0, 1'b1, 6'd1, 4'hf, '0);
    cyc("R10 adv", 1'b0, 3'b111, 1'b1, 1'b1, 6'd1, 4'hf, '0);
    cyc("R10 adv", 1'b0, 3'b111, 1'b1, 1'b0, 6'd1, 4'h0, 36'h123456789);
    nop("R10 check", '0);

    // R7: stall during read data phase, then during write data phase
    cyc("R7 rd", 1'b0, 3'b111, 1'b0, 1'b1, 6'd7, 4'hf, '0);
    for (int i = 0; i < 3; i++) cyc("R7 stall rd", 1'b1, 3'b111, 1'b0, 1'b0, 6'd9, 4'h0, '1);
    cyc("R7 wr", 1'b0, 3'b111, 1'b0, 1'b0, 6'd9, 4'h0, '0);
    for (int i = 0; i < 2; i++) cyc("R7 stall wr", 1'b1, 3'b000, 1'b0, 1'b1, 6'd0, 4'hf, pat(6'(i), 3'd3));
    cyc("R7 commit", 1'b0, 3'b111, 1'b0, 1'b1, 6'd9, 4'hf, pat(6'd9, 3'd7));
    nop("R7 check", '0);

    // R8: linear read burst from 6, five beats (wrap), then linear write burst
    order_i = 1'b0;
    cyc("R8 ld", 1'b0, 3'b111, 1'b0, 1'b1, 6'd6, 4'hf, '0);
    for (int i = 0; i < 4; i++) cyc("R8 beat", 1'b0, 3'b000, 1'b1, 1'b0, 6'd0, 4'h0, '0);
    cyc("R8 wld", 1'b0, 3'b111, 1'b0, 1'b0, 6'd29, 4'h0, '0);
    for (int i = 0; i < 3; i++) cyc("R8 wbeat", 1'b0, 3'b000, 1'b1, 1'b1, 6'd0, 4'(i), pat(6'(i), 3'd2));
    cyc("R8 rchk", 1'b0, 3'b111, 1'b0, 1'b1, 6'd28, 4'hf, pat(6'd3, 3'd2));
    for (int i = 0; i < 3; i++) cyc("R8 rbeat", 1'b0, 3'b111, 1'b1, 1'b1, 6'd0, 4'hf, '0);
    nop("R8 tail", '0);

    // R9: interleaved bursts from each start offset
    order_i = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cyc("R9 ld", 1'b0, 3'b111, 1'b0, 1'b1, 6'(48 + s), 4'hf, '0);
      for (int i = 0; i < 3; i++) cyc("R9 beat", 1'b0, 3'b111, 1'b1, 1'b0, 6'd0, 4'hf, '0);
    end
    cyc("R9 wld", 1'b0, 3'b111, 1'b0, 1'b0, 6'd14, 4'h0, '0);
    for (int i = 0; i < 3; i++) cyc("R9 wbeat", 1'b0, 3'b111, 1'b1, 1'b1, 6'd0, 4'h0, pat(6'(i), 3'd4));
    cyc("R9 rchk", 1'b0, 3'b111, 1'b0, 1'b1, 6'd12, 4'hf, pat(6'd3, 3'd4));
    for (int i = 0; i < 3; i++) cyc("R9 rbeat", 1'b0, 3'b111, 1'b1, 1'b1, 6'd0, 4'hf, '0);
    nop("R9 tail", '0);
    nop("end", '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule